// File: doc/BRIEF.md
# Sensor Bus Target with Wait-State and Start-Pulse Timing

This block sits on a synchronous processor bus clocked at 10 MHz and answers accesses aimed at a slow measurement sensor. It compares six decoded address bits, the active-low chip select and the read/write strobe with two configured addresses. One address reads the sensor's data register and the other starts a measurement.

A read of the data register turns on the sensor's output enable for the whole access. The eight sensor bits appear on the top byte of the processor data bus in reversed bit order. The block returns an active-low transfer acknowledge after a configurable number of wait states, which is zero by default.

A write to the start address raises the start-of-measurement pulse. The pulse lasts as many bus clocks as a minimum width in nanoseconds requires. By default that is 200 ns at a 100 ns clock, so two clocks. The acknowledge is held back until the last of those clocks, which gives one wait state by default.

All outputs are decoded from the current bus inputs and a small phase counter. They change only with the bus inputs or at a clock edge, so the quarter-cycle setup and hold margins around the processor's sampling edge are kept.

The bus handshake is the processor's own request/acknowledge pair: chip select asserted acts as the request and the acknowledge pulse as completion. Holding chip select low is the only form of back-pressure. The block never stalls the requester in any other way. The address and direction must stay stable while chip select is low.

Top module: `bw_sensor_target`

## Requirements
- R1: While reset is asserted and right after it is released with the bus idle, ta_n is 1, sm is 0, sens_oe is 0 and bus_dat is all zeros.
- R2: When cs_n is 0, rd_wr is 1 (1 means read) and addr equals RD_ADDR, sens_oe is 1 for every cycle of the access. ta_n is 0 only in the access's cycle number RD_WAIT, counting the first cycle as 0. With the default RD_WAIT of 0 this is the first cycle.
- R3: When cs_n is 0, rd_wr is 0 and addr equals SM_ADDR, sm is 1 for every cycle of the access. ta_n is 0 only in cycle SM_CYC-1 of the access, where SM_CYC = ceil(SM_MIN_NS / CLK_NS) with a minimum of 1. The default is 2 cycles, with the acknowledge in the second.
- R4: While sens_oe is 1, bus_dat[BUS_W-1-i] equals sens_d[i] for every i below DATA_W, and all lower bus bits are 0. While sens_oe is 0, bus_dat is all zeros.
- R5: While cs_n is 1, ta_n is 1 and sm and sens_oe are 0, whatever the address, direction and sensor data.
- R6: A read of SM_ADDR, a write of RD_ADDR, or an access to any other address gives ta_n 1, sm 0 and sens_oe 0 for as long as it lasts.
- R7: If cs_n stays 0 past an acknowledge, a new access starts in the next cycle and is timed from its own cycle 0.
- R8: If cs_n returns to 1 before the acknowledge, the access is dropped without an acknowledge, and the next access is timed from cycle 0.
- R9: The cycle counts follow the parameters. With SM_MIN_NS of 250 at CLK_NS of 100, sm lasts 3 cycles and is acknowledged in the third. With RD_WAIT of 1, a read is acknowledged in its second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select for the sensor window |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W (6) | Decoded address bits of the access |
| sens_d | input | DATA_W (8) | Sensor data register output |
| sens_oe | output | 1 | Sensor data output enable |
| sm | output | 1 | Start-of-measurement pulse, active high |
| ta_n | output | 1 | Active-low transfer acknowledge |
| bus_dat | output | BUS_W (32) | Processor data bus; sensor bits reversed on the top byte |

## Verification
The bench builds two copies side by side from the same stimulus. The first uses the default parameters: a read acknowledged with no wait state and a two-clock start pulse. The second uses SM_MIN_NS of 250 and RD_WAIT of 1, which exercises the rounded-up three-clock pulse and a one-wait-state read. Between them, the stimulus covers:
- back-to-back accesses under a held chip select;
- aborted writes;
- wrong-direction and off-address accesses.

Together these show that the acknowledge position and the pulse length come from the parameters and are not fixed in the logic.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_START = 2'd2
  } acc_e;
endpackage

// File: rtl/bw_decode.sv
module bw_decode
  import bw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] RD_ADDR = 6'h21,
  parameter logic [ADDR_W-1:0] SM_ADDR = 6'h22
) (
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              kind
);
  always_comb begin
    kind = ACC_NONE;
    if (!cs_n) begin
      if (rd_wr && addr == RD_ADDR)       kind = ACC_READ;
      else if (!rd_wr && addr == SM_ADDR) kind = ACC_START;
    end
  end
endmodule

// File: rtl/bw_phase.sv
module bw_phase
  import bw_pkg::*;
#(
  parameter int RD_WAIT = 0,
  parameter int SM_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  acc_e kind,
  output logic last
);
  localparam int MAXC = (RD_WAIT + 1 > SM_CYC) ? RD_WAIT + 1 : SM_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] RD_LAST = CW'(RD_WAIT);
  localparam logic [CW-1:0] SM_LAST = CW'(SM_CYC - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    unique case (kind)
      ACC_READ:  last = (cnt == RD_LAST);
      ACC_START: last = (cnt == SM_LAST);
      default:   last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (kind == ACC_NONE || last) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  // R7/R8: an idle cycle always leaves the counter at the start of an access
  a_r8_restart_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    kind == ACC_NONE |=> cnt == '0);
  // R3: counter never passes the last phase of a start access
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    kind == ACC_START |-> cnt <= SM_LAST);
endmodule

// File: rtl/bw_lane.sv
module bw_lane #(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              oe,
  input  logic [DATA_W-1:0] sens_d,
  output logic [BUS_W-1:0]  bus_dat
);
  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (i >= BUS_W - DATA_W) begin : g_hi
      assign bus_dat[i] = oe & sens_d[BUS_W-1-i];
    end else begin : g_lo
      assign bus_dat[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bw_sensor_target.sv
module bw_sensor_target
  import bw_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int BUS_W     = 32,
  parameter logic [ADDR_W-1:0] RD_ADDR = 6'h21,
  parameter logic [ADDR_W-1:0] SM_ADDR = 6'h22,
  parameter int CLK_NS    = 100,
  parameter int SM_MIN_NS = 200,
  parameter int RD_WAIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] sens_d,
  output logic              sens_oe,
  output logic              sm,
  output logic              ta_n,
  output logic [BUS_W-1:0]  bus_dat
);
  localparam int SM_RAW = (SM_MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int SM_CYC = (SM_RAW < 1) ? 1 : SM_RAW;

  acc_e kind;
  logic last;

  bw_decode #(.ADDR_W(ADDR_W), .RD_ADDR(RD_ADDR), .SM_ADDR(SM_ADDR)) u_dec (
    .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr), .kind(kind));

  bw_phase #(.RD_WAIT(RD_WAIT), .SM_CYC(SM_CYC)) u_ph (
    .clk(clk), .rst_n(rst_n), .kind(kind), .last(last));

  assign sens_oe = (kind == ACC_READ);
  assign sm      = (kind == ACC_START);
  assign ta_n    = ~last;

  bw_lane #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_lane (
    .oe(sens_oe), .sens_d(sens_d), .bus_dat(bus_dat));

  a_r5_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ta_n && !sm && !sens_oe));
  a_r3_sm_ends_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sm) |-> ($past(!ta_n) || $past(cs_n) || cs_n));
  a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(sens_oe && sm));
  a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_oe |-> bus_dat == '0);
  a_r2_ack_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |-> (sens_oe || sm));
endmodule

// File: tb/sim_bw_sensor_target.sv
module sim_bw_sensor_target;
  localparam logic [5:0] RDA = 6'h21;
  localparam logic [5:0] SMA = 6'h22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rd_wr = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] sens_d = '0;
  logic oe0, sm0, ta0, oe1, sm1, ta1;
  logic [31:0] bd0, bd1;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int ph[2] = '{0, 0};
  int rdw[2] = '{0, 1};
  int smc[2] = '{2, 3};

  always #10 clk = ~clk;

  bw_sensor_target u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .sens_d(sens_d), .sens_oe(oe0), .sm(sm0), .ta_n(ta0), .bus_dat(bd0));

  bw_sensor_target #(.SM_MIN_NS(250), .RD_WAIT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .sens_d(sens_d), .sens_oe(oe1), .sm(sm1), .ta_n(ta1), .bus_dat(bd1));

  task automatic chk(input string what, input int inst, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s u%0d %s actual=%h expected=%h", cur_req, inst, what, act, exp);
    end
  endtask

  // behavioural expectation for instance i given current inputs
  task automatic compare(input int i);
    bit rd_hit, st_hit, ack;
    logic [31:0] eb;
    rd_hit = !cs_n && rd_wr && addr == RDA;
    st_hit = !cs_n && !rd_wr && addr == SMA;
    ack = (rd_hit && ph[i] == rdw[i]) || (st_hit && ph[i] == smc[i] - 1);
    eb = '0;
    if (rd_hit) for (int b = 0; b < 8; b++) eb[31-b] = sens_d[b];
    if (i == 0) begin
      chk("sens_oe", 0, {31'b0, oe0}, {31'b0, rd_hit});
      chk("sm", 0, {31'b0, sm0}, {31'b0, st_hit});
      chk("ta_n", 0, {31'b0, ta0}, {31'b0, !ack});
      chk("bus_dat", 0, bd0, eb);
    end else begin
      chk("sens_oe", 1, {31'b0, oe1}, {31'b0, rd_hit});
      chk("sm", 1, {31'b0, sm1}, {31'b0, st_hit});
      chk("ta_n", 1, {31'b0, ta1}, {31'b0, !ack});
      chk("bus_dat", 1, bd1, eb);
    end
  endtask

  task automatic advance(input int i);
    bit rd_hit, st_hit, ack;
    rd_hit = !cs_n && rd_wr && addr == RDA;
    st_hit = !cs_n && !rd_wr && addr == SMA;
    ack = (rd_hit && ph[i] == rdw[i]) || (st_hit && ph[i] == smc[i] - 1);
    if (!rst_n || !(rd_hit || st_hit) || ack) ph[i] = 0;
    else ph[i] = ph[i] + 1;
  endtask

  task automatic cyc(input logic c, input logic r, input logic [5:0] a,
                     input logic [7:0] d);
    @(negedge clk);
    cs_n = c; rd_wr = r; addr = a; sens_d = d;
    #5;
    compare(0); compare(1);
    @(posedge clk);
    advance(0); advance(1);
  endtask

  task automatic access(input logic r, input logic [5:0] a, input logic [7:0] d,
                        input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, r, a, d);
  endtask

  initial begin
    cur_req = "R1";
    cyc(1'b1, 1'b1, RDA, 8'hFF);
    cyc(1'b1, 1'b0, SMA, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b1, 1'b1, RDA, 8'h00);
    cur_req = "R5";
    cyc(1'b1, 1'b1, RDA, 8'hC3);
    cyc(1'b1, 1'b0, SMA, 8'h3C);
    cur_req = "R2";
    access(1'b1, RDA, 8'hA5, 2);
    cyc(1'b1, 1'b1, RDA, 8'hA5);
    cur_req = "R4";
    access(1'b1, RDA, 8'h01, 2);
    cyc(1'b1, 1'b1, 6'h00, 8'h01);
    access(1'b1, RDA, 8'h80, 2);
    cyc(1'b1, 1'b1, 6'h00, 8'h80);
    cur_req = "R3";
    access(1'b0, SMA, 8'h00, 2);
    cyc(1'b1, 1'b0, SMA, 8'h00);
    cur_req = "R9";
    access(1'b0, SMA, 8'h00, 3);
    cyc(1'b1, 1'b0, SMA, 8'h00);
    access(1'b1, RDA, 8'h5A, 2);
    cyc(1'b1, 1'b0, SMA, 8'h00);
    cur_req = "R7";
    access(1'b0, SMA, 8'h11, 6);
    access(1'b1, RDA, 8'h69, 4);
    cyc(1'b1, 1'b0, SMA, 8'h00);
    cur_req = "R6";
    access(1'b1, SMA, 8'hEE, 3);
    access(1'b0, RDA, 8'hEE, 3);
    access(1'b1, 6'h3F, 8'hEE, 2);
    access(1'b0, 6'h00, 8'hEE, 2);
    cyc(1'b1, 1'b0, SMA, 8'h00);
    cur_req = "R8";
    access(1'b0, SMA, 8'h00, 1);
    cyc(1'b1, 1'b0, SMA, 8'h00);
    access(1'b0, SMA, 8'h00, 3);
    cyc(1'b1, 1'b1, RDA, 8'h00);
    access(1'b1, RDA, 8'h7E, 1);
    cyc(1'b1, 1'b1, RDA, 8'h00);
    access(1'b1, RDA, 8'h7E, 2);
    cyc(1'b1, 1'b1, RDA, 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule